// File: doc/BRIEF.md
# Two-Thread Shared Decoded-Line Cache

This block is a set-associative store of decoded-operation lines that two hardware threads use together. Each thread keeps its own fetch pointer, which software or a redirect path can load. Each thread raises its own request line. Every clock, an arbiter picks at most one thread. The chosen pointer looks up the cache, and that pointer then steps to the next line.

Each stored entry holds the id of the thread that installed it, next to its address tag. A lookup hits only when both the tag and the thread id match. The registered response carries the hit flag, the line data, the thread and the address that was looked up. Lines come in through a fill port. A fill takes the lowest-numbered free way first; when the set is full it takes the least-recently-used way. The recency order covers all ways of the set, and neither thread has a quota.

With the default parameters the cache has 64 sets and 8 ways. Addresses are 32 bits, lines are 64 bits, and each line covers 8 bytes. Address bits [2:0] are the offset, bits [8:3] select the set, and bits [31:9] form the tag.

Top module: `shared_line_cache`

## Requirements
- R1: Each thread has its own fetch pointer. `ptr_load[t]` loads `ptr_load_addr` into pointer t. Otherwise, a grant to thread t adds 8 to pointer t at the same edge. A pointer that is neither loaded nor granted keeps its value.
- R2: Arbitration runs every cycle and is combinational. `grant` is one-hot or zero, and it never grants a thread that is not requesting. Any request at all produces a grant.
- R3: When both threads request, the grant alternates between them cycle by cycle. The first contended grant after reset goes to thread 0 (`grant` = 2'b01).
- R4: A thread that requests alone is granted every cycle. Such cycles leave the alternation state unchanged.
- R5: One cycle after any grant, `rsp_vld` is 1, with `rsp_tid` set to the granted thread and `rsp_addr` set to the pointer used. In every other cycle `rsp_vld` is 0.
- R6: A response is a hit only when a valid way of the addressed set has the same tag and the same thread id. A line that the other thread filled at the same address misses.
- R7: A miss reports `rsp_hit` = 0 and `rsp_data` = 0. A hit returns the stored line.
- R8: A fill installs into the lowest-numbered invalid way of its set. Lines filled into a set that still has a free way never evict each other.
- R9: A fill into a full set replaces the least-recently-used way. Both a hit and a fill make their way the most recent. If a hit and a fill touch the same set in one cycle, only the fill updates the order.
- R10: Either thread may occupy all 8 ways of a set.
- R11: A lookup in the same cycle as a fill of the same line sees the contents from before the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 2 | Per-thread lookup request |
| ptr_load | input | 2 | Per-thread pointer load strobe |
| ptr_load_addr | input | 32 | Address to load into the fetch pointer |
| fill_vld | input | 1 | Install a line |
| fill_tid | input | 1 | Thread that owns the filled line |
| fill_addr | input | 32 | Address of the filled line |
| fill_data | input | 64 | Line payload |
| grant | output | 2 | One-hot thread grant this cycle |
| rsp_vld | output | 1 | Lookup result valid |
| rsp_tid | output | 1 | Thread of the result |
| rsp_hit | output | 1 | Lookup hit |
| rsp_addr | output | 32 | Address that was looked up |
| rsp_data | output | 64 | Line on hit, zero on miss |

## Verification
The assertions check the following on every cycle: the arbiter grants only requesting threads and at most one of them; contention alternates; a lone requester gets the full bandwidth; a response follows exactly the cycles that had a grant; pointers hold when idle; and each set keeps exactly one oldest way. The bench scenarios are the only place that shows the cache contents behave correctly. Those scenarios cover the thread-id mismatch on an equal address, filling into free ways, the choice of eviction victim after a hit reorders the set, one thread filling a whole set, and the old-data view when a fill and a lookup meet in one cycle.

// File: rtl/slc_pkg.sv
package slc_pkg;
   localparam int NUM_THR = 2;
   typedef logic [NUM_THR-1:0] thr_vec_t;
endpackage

// File: rtl/slc_arbiter.sv
module slc_arbiter
   import slc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  thr_vec_t req,
   output thr_vec_t grant
);
   logic turn_q;    // 0: thread 0 wins next contention
   logic seen_q;    // one cycle has passed since reset

   always_comb begin
      if (req == 2'b11) grant = turn_q ? 2'b10 : 2'b01;
      else              grant = req;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         turn_q <= 1'b0;
         seen_q <= 1'b0;
      end else begin
         seen_q <= 1'b1;
         if (req == 2'b11) turn_q <= ~turn_q;
      end
   end

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R2
   AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~req) == 2'b00); // R2
   AST_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && req == 2'b11 && $past(req) == 2'b11) |-> grant != $past(grant)); // R3
   AST_SOLO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      ($onehot(req)) |-> grant == req); // R4
endmodule

// File: rtl/slc_fetch_ptr.sv
module slc_fetch_ptr #(
   parameter int ADDR_W = 32,
   parameter int STEP   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              adv,
   output logic [ADDR_W-1:0] ptr
);
   always_ff @(posedge clk) begin
      if (!rst_n)    ptr <= '0;
      else if (load) ptr <= load_addr;
      else if (adv)  ptr <= ptr + ADDR_W'(STEP);
   end

   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !adv) |=> $stable(ptr)); // R1
endmodule

// File: rtl/slc_lru_ages.sv
module slc_lru_ages #(
   parameter int SETS = 64,
   parameter int WAYS = 8,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_vld,
   input  logic [SET_W-1:0] hit_set,
   input  logic [WAY_W-1:0] hit_way,
   input  logic             fill_vld,
   input  logic [SET_W-1:0] fill_set,
   input  logic [WAY_W-1:0] fill_way,
   output logic [WAY_W-1:0] lru_way
);
   // per-way age: 0 = most recent, WAYS-1 = least recent; a set is a permutation
   logic [WAY_W-1:0] age_q [SETS][WAYS];
   logic [WAYS-1:0]  oldest;
   logic             hit_upd;

   assign hit_upd = hit_vld && !(fill_vld && fill_set == hit_set);

   always_comb begin
      lru_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         oldest[w] = (age_q[fill_set][w] == WAY_W'(WAYS-1));
         if (oldest[w]) lru_way = WAY_W'(w);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
               age_q[s][w] <= WAY_W'(w);
      end else begin
         if (hit_upd) begin
            for (int w = 0; w < WAYS; w++) begin
               if (WAY_W'(w) == hit_way)
                  age_q[hit_set][w] <= '0;
               else if (age_q[hit_set][w] < age_q[hit_set][hit_way])
                  age_q[hit_set][w] <= age_q[hit_set][w] + 1'b1;
            end
         end
         if (fill_vld) begin
            for (int w = 0; w < WAYS; w++) begin
               if (WAY_W'(w) == fill_way)
                  age_q[fill_set][w] <= '0;
               else if (age_q[fill_set][w] < age_q[fill_set][fill_way])
                  age_q[fill_set][w] <= age_q[fill_set][w] + 1'b1;
            end
         end
      end
   end

   AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(oldest) == 1); // R9
endmodule

// File: rtl/shared_line_cache.sv
module shared_line_cache
   import slc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64,
   parameter int SETS   = 64,
   parameter int WAYS   = 8,
   parameter int OFF_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        req,
   input  logic [1:0]        ptr_load,
   input  logic [ADDR_W-1:0] ptr_load_addr,
   input  logic              fill_vld,
   input  logic              fill_tid,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic [DATA_W-1:0] fill_data,
   output logic [1:0]        grant,
   output logic              rsp_vld,
   output logic              rsp_tid,
   output logic              rsp_hit,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic [DATA_W-1:0] rsp_data
);
   localparam int SET_W = $clog2(SETS);
   localparam int WAY_W = $clog2(WAYS);
   localparam int TAG_W = ADDR_W - SET_W - OFF_W;
   localparam int STEP  = 1 << OFF_W;

   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two, at least 2");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("address too narrow for sets and offset");
   end

   // ---------------- arbitration and pointers ----------------
   thr_vec_t          gnt;
   logic [ADDR_W-1:0] ptr [NUM_THR];

   slc_arbiter u_arb (.clk(clk), .rst_n(rst_n), .req(req), .grant(gnt));
   assign grant = gnt;

   for (genvar t = 0; t < NUM_THR; t++) begin : g_ptr
      slc_fetch_ptr #(.ADDR_W(ADDR_W), .STEP(STEP)) u_ptr (
         .clk(clk), .rst_n(rst_n),
         .load(ptr_load[t]), .load_addr(ptr_load_addr),
         .adv(gnt[t]), .ptr(ptr[t]));
   end

   // ---------------- storage ----------------
   logic              vld_q  [SETS][WAYS];
   logic              tid_q  [SETS][WAYS];
   logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
   logic [DATA_W-1:0] data_q [SETS][WAYS];

   // ---------------- lookup ----------------
   logic              lk_go, lk_tid;
   logic [ADDR_W-1:0] lk_addr;
   logic [SET_W-1:0]  lk_set;
   logic [TAG_W-1:0]  lk_tag;
   logic [WAYS-1:0]   hit_vec;
   logic [WAY_W-1:0]  hit_way;
   logic [DATA_W-1:0] hit_data;

   assign lk_go   = |gnt;
   assign lk_tid  = gnt[1];
   assign lk_addr = lk_tid ? ptr[1] : ptr[0];
   assign lk_set  = lk_addr[OFF_W +: SET_W];
   assign lk_tag  = lk_addr[ADDR_W-1 -: TAG_W];

   always_comb begin
      hit_way  = '0;
      hit_data = '0;
      for (int w = 0; w < WAYS; w++) begin
         hit_vec[w] = vld_q[lk_set][w] && (tid_q[lk_set][w] == lk_tid)
                      && (tag_q[lk_set][w] == lk_tag);
         if (hit_vec[w]) begin
            hit_way  = WAY_W'(w);
            hit_data = data_q[lk_set][w];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_vld  <= 1'b0;
         rsp_tid  <= 1'b0;
         rsp_hit  <= 1'b0;
         rsp_addr <= '0;
         rsp_data <= '0;
      end else begin
         rsp_vld  <= lk_go;
         rsp_tid  <= lk_tid;
         rsp_hit  <= lk_go && (|hit_vec);
         rsp_addr <= lk_addr;
         rsp_data <= lk_go ? hit_data : '0;
      end
   end

   // ---------------- fill ----------------
   logic [SET_W-1:0] fl_set;
   logic [TAG_W-1:0] fl_tag;
   logic [WAY_W-1:0] lru_way, fl_way;
   logic             free_found;

   assign fl_set = fill_addr[OFF_W +: SET_W];
   assign fl_tag = fill_addr[ADDR_W-1 -: TAG_W];

   always_comb begin
      fl_way     = lru_way;
      free_found = 1'b0;
      for (int w = 0; w < WAYS; w++) begin
         if (!free_found && !vld_q[fl_set][w]) begin
            fl_way     = WAY_W'(w);
            free_found = 1'b1;
         end
      end
   end

   slc_lru_ages #(.SETS(SETS), .WAYS(WAYS)) u_lru (
      .clk(clk), .rst_n(rst_n),
      .hit_vld(lk_go && (|hit_vec)), .hit_set(lk_set), .hit_way(hit_way),
      .fill_vld(fill_vld), .fill_set(fl_set), .fill_way(fl_way),
      .lru_way(lru_way));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
               vld_q[s][w] <= 1'b0;
      end else if (fill_vld) begin
         vld_q[fl_set][fl_way] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_vld) begin
         tid_q[fl_set][fl_way]  <= fill_tid;
         tag_q[fl_set][fl_way]  <= fl_tag;
         data_q[fl_set][fl_way] <= fill_data;
      end
   end

   AST_RSP_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (|gnt) |=> (rsp_vld && rsp_tid == $past(gnt[1]))); // R5
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !(|gnt) |=> !rsp_vld); // R5
endmodule

// File: tb/sim_shared_line_cache.sv
module sim_shared_line_cache;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  req = '0;
   logic [1:0]  ptr_load = '0;
   logic [31:0] ptr_load_addr = '0;
   logic        fill_vld = 1'b0;
   logic        fill_tid = 1'b0;
   logic [31:0] fill_addr = '0;
   logic [63:0] fill_data = '0;
   logic [1:0]  grant;
   logic        rsp_vld, rsp_tid, rsp_hit;
   logic [31:0] rsp_addr;
   logic [63:0] rsp_data;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   shared_line_cache u0 (.*);

   // {req[1:0], expected grant[1:0]} per consecutive cycle
   localparam logic [3:0] ARB_VEC [9] = '{
      4'b1101, 4'b1110, 4'b0101, 4'b1010, 4'b1101,
      4'b0101, 4'b1110, 4'b0000, 4'b1101 };

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   function automatic logic [31:0] adr(input int tag, input int set);
      return 32'(tag) * 32'd512 + 32'(set) * 32'd8;
   endfunction

   task automatic fill(input bit t, input logic [31:0] a, input logic [63:0] d);
      @(negedge clk);
      fill_vld = 1'b1; fill_tid = t; fill_addr = a; fill_data = d;
      @(negedge clk);
      fill_vld = 1'b0;
   endtask

   task automatic lookup(input bit t, input logic [31:0] a, input bit ehit,
                         input logic [63:0] edata, input string rq);
      @(negedge clk);
      ptr_load = '0; ptr_load[t] = 1'b1; ptr_load_addr = a;
      @(negedge clk);
      ptr_load = '0; req = '0; req[t] = 1'b1;
      @(negedge clk);
      req = '0;
      check(rsp_vld && rsp_tid == t && rsp_addr == a && rsp_hit == ehit
            && rsp_data == (ehit ? edata : 64'd0), rq, "lookup",
            {rsp_hit, 31'd0, rsp_addr}, {ehit, 31'd0, a});
      if (ehit) check(rsp_data == edata, rq, "data", rsp_data, edata);
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int cnt0, cnt1;
      logic prev_any;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(grant == 2'b00 && !rsp_vld, "R2", "reset idle", {grant, rsp_vld}, 0);

      // pointer bases
      @(negedge clk);
      ptr_load = 2'b01; ptr_load_addr = 32'h1000;
      @(negedge clk);
      ptr_load = 2'b10; ptr_load_addr = 32'h2000;
      @(negedge clk);
      ptr_load = 2'b00;

      // arbitration table
      cnt0 = 0; cnt1 = 0; prev_any = 1'b0;
      for (int i = 0; i < 9; i++) begin
         req = ARB_VEC[i][3:2];
         #1;
         check(grant == ARB_VEC[i][1:0], "R3", $sformatf("arb row %0d (R4 solo)", i),
               grant, ARB_VEC[i][1:0]);
         check(rsp_vld == prev_any, "R5", "rsp follows grant", rsp_vld, prev_any);
         prev_any = |ARB_VEC[i][1:0];
         if (ARB_VEC[i][1:0] == 2'b01) cnt0++;
         if (ARB_VEC[i][1:0] == 2'b10) cnt1++;
         @(negedge clk);
      end
      req = '0;
      check(rsp_vld == prev_any, "R5", "rsp after last row", rsp_vld, prev_any);

      // pointer advance per thread (R1)
      @(negedge clk);
      req = 2'b01;
      @(negedge clk);
      req = 2'b00;
      check(rsp_addr == 32'h1000 + 32'(cnt0) * 8 && rsp_tid == 1'b0, "R1", "ptr0",
            rsp_addr, 32'h1000 + 32'(cnt0) * 8);
      @(negedge clk);
      req = 2'b10;
      @(negedge clk);
      req = 2'b00;
      check(rsp_addr == 32'h2000 + 32'(cnt1) * 8 && rsp_tid == 1'b1, "R1", "ptr1",
            rsp_addr, 32'h2000 + 32'(cnt1) * 8);
      @(negedge clk);
      check(!rsp_vld, "R5", "idle no rsp", rsp_vld, 0);

      // miss returns zero (R7), thread id match (R6)
      lookup(0, adr(3, 4), 0, 0, "R7");
      fill(0, adr(3, 4), 64'hA5A5_0000_0000_0003);
      lookup(0, adr(3, 4), 1, 64'hA5A5_0000_0000_0003, "R7");
      lookup(1, adr(3, 4), 0, 0, "R6");

      // free ways first (R8), then LRU (R9)
      for (int k = 1; k <= 8; k++) fill(0, adr(k, 5), 64'h5500 + 64'(k));
      for (int k = 1; k <= 8; k++) lookup(0, adr(k, 5), 1, 64'h5500 + 64'(k), "R8");
      // hits above touched 1..8 in order; touch 1 again so 2 is oldest
      lookup(0, adr(1, 5), 1, 64'h5501, "R9");
      fill(0, adr(9, 5), 64'h5509);
      lookup(0, adr(2, 5), 0, 0, "R9");
      lookup(0, adr(9, 5), 1, 64'h5509, "R9");
      lookup(0, adr(1, 5), 1, 64'h5501, "R9");
      // set is full: next victim is the oldest, tag 3; fill comes from thread 1
      fill(1, adr(20, 5), 64'h6620);
      lookup(0, adr(3, 5), 0, 0, "R9");
      lookup(1, adr(20, 5), 1, 64'h6620, "R9");

      // one thread owns a whole set (R10)
      for (int k = 1; k <= 8; k++) fill(1, adr(k, 7), 64'h7700 + 64'(k));
      for (int k = 1; k <= 8; k++) lookup(1, adr(k, 7), 1, 64'h7700 + 64'(k), "R10");
      lookup(0, adr(4, 7), 0, 0, "R6");

      // fill and lookup in the same cycle (R11)
      @(negedge clk);
      ptr_load = 2'b01; ptr_load_addr = adr(11, 12);
      @(negedge clk);
      ptr_load = 2'b00; req = 2'b01;
      fill_vld = 1'b1; fill_tid = 1'b0; fill_addr = adr(11, 12); fill_data = 64'hBEEF;
      @(negedge clk);
      req = 2'b00; fill_vld = 1'b0;
      check(rsp_vld && !rsp_hit && rsp_data == 0, "R11", "old view", rsp_hit, 0);
      lookup(0, adr(11, 12), 1, 64'hBEEF, "R11");

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule